// File: doc/BRIEF.md
# Tile Link Framer and Filter

This block moves byte frames between neighbouring compute tiles over a short point-to-point link. Its transmit half takes a frame header (a payload type and a payload length) and then the payload bytes over a valid/ready handshake. It sends a one-byte preamble, then a length byte, then the payload. The preamble names the sending port and the payload type, which together identify the routing path.

The transmit half can keep only a window of the payload, set by a start offset and a byte count. The length byte then carries the size of that window. The link has two control lines. An activity line marks the whole frame. A strobe marks each byte that is valid. Gaps in the strobe are allowed while the activity line stays high.

The receive half reads the preamble and checks a routing-enable mask indexed by the source port. Frames from a source that is not enabled are counted and discarded. For an accepted frame, the receiver applies its own byte window and forwards only the bytes inside that window. It also reports when a frame finishes normally and when a frame is cut short.

Top module: `core_link_ctrl`

## Requirements
- R1: Every transmitted frame is a preamble byte, then a length byte, then the kept payload bytes. The activity line is high from the preamble through the last payload byte, and the byte strobe is never high while the activity line is low.
- R2: Preamble layout: bits 2..0 hold the transmitter's port id, bits 5..3 hold the payload type, and bits 7..6 are zero.
- R3: The transmitter puts on the link only the payload bytes whose index lies in [start, start+count) of its own window, which is captured when the header is accepted. The length byte equals the number of such bytes that exist in the payload.
- R4: A frame is dropped when the enable bit indexed by preamble bits 2..0 is clear, or when preamble bits 7..6 are not zero. A dropped frame produces no forwarded byte and no done pulse, and it raises the drop counter by one.
- R5: The drop counter saturates at all ones.
- R6: For an accepted frame, received payload byte k is forwarded only if k lies in [start, start+count) of the receive window, which is captured with the preamble. Bytes keep their order and value. The output strobe comes one cycle after the link byte, with the preamble's source and type shown alongside.
- R7: The done flag pulses for one cycle when the count of received payload bytes reaches the length byte. A length of zero completes the frame on the length byte.
- R8: If the activity line drops after an accepted preamble and before the length is reached, the error flag pulses for one cycle and no done pulse is given.
- R9: A new header is accepted only when the transmitter is idle, that is after the previous frame's last byte has been sent. Payload bytes are taken only while payload is expected.
- R10: Payloads of 0 to 255 bytes are delivered byte-exact, including windows whose end passes byte 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_port_id | input | 3 | Port id placed in the preamble |
| tx_win_start | input | 8 | First payload index kept by the transmitter |
| tx_win_cnt | input | 8 | Number of payload bytes kept by the transmitter |
| tx_hdr_valid | input | 1 | Frame header offered |
| tx_hdr_ready | output | 1 | Transmitter idle, header accepted |
| tx_hdr_type | input | 3 | Payload type of the offered frame |
| tx_hdr_len | input | 8 | Payload length of the offered frame |
| tx_valid | input | 1 | Payload byte offered |
| tx_ready | output | 1 | Payload byte accepted |
| tx_data | input | 8 | Payload byte |
| tx_link_act | output | 1 | Outgoing frame activity line |
| tx_link_vld | output | 1 | Outgoing byte strobe |
| tx_link_data | output | 8 | Outgoing link byte |
| rx_route_en | input | 8 | Receive enable, one bit per source port |
| rx_win_start | input | 8 | First payload index forwarded by the receiver |
| rx_win_cnt | input | 8 | Number of payload bytes forwarded by the receiver |
| rx_link_act | input | 1 | Incoming frame activity line |
| rx_link_vld | input | 1 | Incoming byte strobe |
| rx_link_data | input | 8 | Incoming link byte |
| rx_out_valid | output | 1 | Forwarded byte strobe |
| rx_out_data | output | 8 | Forwarded byte |
| rx_out_src | output | 3 | Source port of the current frame |
| rx_out_type | output | 3 | Payload type of the current frame |
| rx_frame_done | output | 1 | Frame completed pulse |
| rx_frame_error | output | 1 | Frame cut short pulse |
| rx_drop_cnt | output | DROP_W | Saturating count of dropped frames |

## Verification
The bench builds the block with a three-bit drop counter, so that a handful of disabled-source frames drives the counter to its limit and then tests that it holds there. The transmit output is looped to the receive input through a bench multiplexer. That multiplexer also lets the bench drive the link directly: it can cut the activity line mid-frame and send preambles with reserved bits set. Random frames of up to 255 bytes, with random windows and random payload gaps, cover windows that start past the end of the payload, windows of zero width, and windows whose end passes byte 255.

// File: rtl/link_pkg.sv
// Shared constants and helpers for the tile link framer.
// Assumes an 8-bit link byte and a one-byte preamble of the form
// {2'b00, type[2:0], port[2:0]}.
package link_pkg;
    localparam int BYTE_W = 8;
    localparam int PORT_W = 3;
    localparam int TYPE_W = 3;
    localparam int NPORTS = 1 << PORT_W;

    // True when idx lies in [start, start+cnt), evaluated without wrap.
    function automatic logic in_window(input logic [BYTE_W-1:0] idx,
                                       input logic [BYTE_W-1:0] start,
                                       input logic [BYTE_W-1:0] cnt);
        logic [BYTE_W:0] stop;
        stop = {1'b0, start} + {1'b0, cnt};
        return ({1'b0, idx} >= {1'b0, start}) && ({1'b0, idx} < stop);
    endfunction

    // Number of payload indices in [0,len) that fall inside the window.
    function automatic logic [BYTE_W-1:0] window_len(input logic [BYTE_W-1:0] len,
                                                     input logic [BYTE_W-1:0] start,
                                                     input logic [BYTE_W-1:0] cnt);
        logic [BYTE_W-1:0] rem;
        if (start >= len) return '0;
        rem = len - start;
        return (cnt < rem) ? cnt : rem;
    endfunction

    // Build the preamble byte.
    function automatic logic [BYTE_W-1:0] make_preamble(input logic [PORT_W-1:0] port,
                                                        input logic [TYPE_W-1:0] ptype);
        return {2'b00, ptype, port};
    endfunction
endpackage

// File: rtl/link_tx.sv
// Transmit framer: accepts a header, emits preamble and length byte, then
// passes the payload through, keeping only bytes inside the captured window.
// Assumes the link has no backpressure; payload gaps keep the activity line high.
module link_tx
    import link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_id,
    input  logic [BYTE_W-1:0] win_start,
    input  logic [BYTE_W-1:0] win_cnt,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [TYPE_W-1:0] hdr_type,
    input  logic [BYTE_W-1:0] hdr_len,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [BYTE_W-1:0] pay_data,
    output logic              link_act,
    output logic              link_vld,
    output logic [BYTE_W-1:0] link_data
);
    typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_LEN, TX_PAY} tx_state_t;

    tx_state_t         state_q;
    logic [BYTE_W-1:0] pre_q;
    logic [BYTE_W-1:0] full_len_q;
    logic [BYTE_W-1:0] sent_len_q;
    logic [BYTE_W-1:0] start_q;
    logic [BYTE_W-1:0] cnt_q;
    logic [BYTE_W-1:0] idx_q;

    // Frame sequencing and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            pre_q      <= '0;
            full_len_q <= '0;
            sent_len_q <= '0;
            start_q    <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
        end else begin
            case (state_q)
                TX_IDLE: if (hdr_valid) begin
                    pre_q      <= make_preamble(port_id, hdr_type);
                    full_len_q <= hdr_len;
                    sent_len_q <= window_len(hdr_len, win_start, win_cnt);
                    start_q    <= win_start;
                    cnt_q      <= win_cnt;
                    idx_q      <= '0;
                    state_q    <= TX_PRE;
                end
                TX_PRE: state_q <= TX_LEN;
                TX_LEN: state_q <= (full_len_q == '0) ? TX_IDLE : TX_PAY;
                TX_PAY: if (pay_valid) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == full_len_q - 1'b1) state_q <= TX_IDLE;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Link drive and handshake outputs.
    always_comb begin
        hdr_ready = (state_q == TX_IDLE);
        pay_ready = (state_q == TX_PAY);
        link_act  = (state_q != TX_IDLE);
        link_vld  = 1'b0;
        link_data = '0;
        case (state_q)
            TX_PRE: begin link_vld = 1'b1; link_data = pre_q; end
            TX_LEN: begin link_vld = 1'b1; link_data = sent_len_q; end
            TX_PAY: begin
                link_vld  = pay_valid && in_window(idx_q, start_q, cnt_q);
                link_data = pay_data;
            end
            default: ;
        endcase
    end

    // Count of kept payload bytes in the current frame, for the window check.
    logic [BYTE_W:0] chk_sent_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == TX_IDLE) chk_sent_q <= '0;
        else if (state_q == TX_PAY && link_vld) chk_sent_q <= chk_sent_q + 1'b1;
    end

    AST_VLD_INSIDE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        link_vld |-> link_act); // R1
    AST_PREAMBLE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_act) |-> (link_vld && link_data[7:6] == 2'b00)); // R2
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_PAY) |-> (chk_sent_q <= {1'b0, sent_len_q})); // R3
    AST_HDR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> !link_act); // R9
endmodule

// File: rtl/link_rx.sv
// Receive filter: parses the preamble, checks the per-source enable mask,
// forwards payload bytes inside the captured window and flags completion
// or truncation. Assumes the first strobed byte after the activity line rises
// is the preamble.
module link_rx
    import link_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] route_en,
    input  logic [BYTE_W-1:0] win_start,
    input  logic [BYTE_W-1:0] win_cnt,
    input  logic              link_act,
    input  logic              link_vld,
    input  logic [BYTE_W-1:0] link_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic [PORT_W-1:0] out_src,
    output logic [TYPE_W-1:0] out_type,
    output logic              frame_done,
    output logic              frame_error,
    output logic [DROP_W-1:0] drop_cnt
);
    typedef enum logic [1:0] {RX_IDLE, RX_LEN, RX_PAY, RX_DRAIN} rx_state_t;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    rx_state_t         state_q;
    logic [BYTE_W-1:0] len_q;
    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] start_q;
    logic [BYTE_W-1:0] cnt_q;
    logic              accept;

    // Preamble admission: enabled source and clear reserved bits.
    always_comb accept = route_en[link_data[PORT_W-1:0]] && (link_data[7:6] == 2'b00);

    // Frame parsing, forwarding, status pulses and drop counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RX_IDLE;
            len_q       <= '0;
            idx_q       <= '0;
            start_q     <= '0;
            cnt_q       <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_src     <= '0;
            out_type    <= '0;
            frame_done  <= 1'b0;
            frame_error <= 1'b0;
            drop_cnt    <= '0;
        end else begin
            out_valid   <= 1'b0;
            frame_done  <= 1'b0;
            frame_error <= 1'b0;
            case (state_q)
                RX_IDLE: if (link_act && link_vld) begin
                    out_src  <= link_data[PORT_W-1:0];
                    out_type <= link_data[PORT_W+TYPE_W-1:PORT_W];
                    start_q  <= win_start;
                    cnt_q    <= win_cnt;
                    if (accept) begin
                        state_q <= RX_LEN;
                    end else begin
                        if (drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;
                        state_q <= RX_DRAIN;
                    end
                end
                RX_LEN: begin
                    if (!link_act) begin
                        frame_error <= 1'b1;
                        state_q     <= RX_IDLE;
                    end else if (link_vld) begin
                        len_q <= link_data;
                        idx_q <= '0;
                        if (link_data == '0) begin
                            frame_done <= 1'b1;
                            state_q    <= RX_DRAIN;
                        end else begin
                            state_q <= RX_PAY;
                        end
                    end
                end
                RX_PAY: begin
                    if (!link_act) begin
                        frame_error <= 1'b1;
                        state_q     <= RX_IDLE;
                    end else if (link_vld) begin
                        out_valid <= in_window(idx_q, start_q, cnt_q);
                        out_data  <= link_data;
                        idx_q     <= idx_q + 1'b1;
                        if (idx_q == len_q - 1'b1) begin
                            frame_done <= 1'b1;
                            state_q    <= RX_DRAIN;
                        end
                    end
                end
                RX_DRAIN: if (!link_act) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1)); // R4
    AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == DROP_MAX) |=> (drop_cnt == DROP_MAX)); // R5
    AST_OUT_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(link_vld && link_act)); // R6
    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_error)); // R7
    AST_ERR_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> !$past(link_act)); // R8
endmodule

// File: rtl/core_link_ctrl.sv
// Tile link controller top: a transmit framer and a receive filter that
// share the frame format. The two halves are independent; the chip fabric
// connects one tile's transmit link to a neighbour's receive link.
module core_link_ctrl
    import link_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        tx_port_id,
    input  logic [7:0]        tx_win_start,
    input  logic [7:0]        tx_win_cnt,
    input  logic              tx_hdr_valid,
    output logic              tx_hdr_ready,
    input  logic [2:0]        tx_hdr_type,
    input  logic [7:0]        tx_hdr_len,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [7:0]        tx_data,
    output logic              tx_link_act,
    output logic              tx_link_vld,
    output logic [7:0]        tx_link_data,
    input  logic [7:0]        rx_route_en,
    input  logic [7:0]        rx_win_start,
    input  logic [7:0]        rx_win_cnt,
    input  logic              rx_link_act,
    input  logic              rx_link_vld,
    input  logic [7:0]        rx_link_data,
    output logic              rx_out_valid,
    output logic [7:0]        rx_out_data,
    output logic [2:0]        rx_out_src,
    output logic [2:0]        rx_out_type,
    output logic              rx_frame_done,
    output logic              rx_frame_error,
    output logic [DROP_W-1:0] rx_drop_cnt
);
    link_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_id   (tx_port_id),
        .win_start (tx_win_start),
        .win_cnt   (tx_win_cnt),
        .hdr_valid (tx_hdr_valid),
        .hdr_ready (tx_hdr_ready),
        .hdr_type  (tx_hdr_type),
        .hdr_len   (tx_hdr_len),
        .pay_valid (tx_valid),
        .pay_ready (tx_ready),
        .pay_data  (tx_data),
        .link_act  (tx_link_act),
        .link_vld  (tx_link_vld),
        .link_data (tx_link_data)
    );

    link_rx #(.DROP_W(DROP_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_en    (rx_route_en),
        .win_start   (rx_win_start),
        .win_cnt     (rx_win_cnt),
        .link_act    (rx_link_act),
        .link_vld    (rx_link_vld),
        .link_data   (rx_link_data),
        .out_valid   (rx_out_valid),
        .out_data    (rx_out_data),
        .out_src     (rx_out_src),
        .out_type    (rx_out_type),
        .frame_done  (rx_frame_done),
        .frame_error (rx_frame_error),
        .drop_cnt    (rx_drop_cnt)
    );
endmodule

// File: tb/core_link_ctrl_bench.sv
`timescale 1ns/100ps
module core_link_ctrl_bench;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] tx_port_id = 3'd5;
    logic [7:0] tx_win_start = 8'd0, tx_win_cnt = 8'd255;
    logic tx_hdr_valid = 1'b0, tx_hdr_ready;
    logic [2:0] tx_hdr_type = 3'd0;
    logic [7:0] tx_hdr_len = 8'd0;
    logic tx_valid = 1'b0, tx_ready;
    logic [7:0] tx_data = 8'd0;
    logic tx_link_act, tx_link_vld;
    logic [7:0] tx_link_data;
    logic [7:0] rx_route_en = 8'hFF, rx_win_start = 8'd0, rx_win_cnt = 8'd255;
    logic inj = 1'b0, inj_act = 1'b0, inj_vld = 1'b0;
    logic [7:0] inj_data = 8'd0;
    logic rx_link_act, rx_link_vld;
    logic [7:0] rx_link_data;
    logic rx_out_valid, rx_frame_done, rx_frame_error;
    logic [7:0] rx_out_data;
    logic [2:0] rx_out_src, rx_out_type;
    logic [DW-1:0] rx_drop_cnt;

    assign rx_link_act  = inj ? inj_act  : tx_link_act;
    assign rx_link_vld  = inj ? inj_vld  : tx_link_vld;
    assign rx_link_data = inj ? inj_data : tx_link_data;

    core_link_ctrl #(.DROP_W(DW)) u_core_link_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tx_port_id(tx_port_id), .tx_win_start(tx_win_start), .tx_win_cnt(tx_win_cnt),
        .tx_hdr_valid(tx_hdr_valid), .tx_hdr_ready(tx_hdr_ready),
        .tx_hdr_type(tx_hdr_type), .tx_hdr_len(tx_hdr_len),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_link_act(tx_link_act), .tx_link_vld(tx_link_vld), .tx_link_data(tx_link_data),
        .rx_route_en(rx_route_en), .rx_win_start(rx_win_start), .rx_win_cnt(rx_win_cnt),
        .rx_link_act(rx_link_act), .rx_link_vld(rx_link_vld), .rx_link_data(rx_link_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .rx_out_src(rx_out_src), .rx_out_type(rx_out_type),
        .rx_frame_done(rx_frame_done), .rx_frame_error(rx_frame_error),
        .rx_drop_cnt(rx_drop_cnt)
    );

    int total = 0, bad = 0;
    int done_n, err_n, meta_bad, rdy_bad, lpos;
    int exp_drop = 0;
    logic [7:0] pre_seen, len_seen;
    logic [2:0] exp_src, exp_type;
    logic [7:0] got_q[$];
    logic [7:0] pay[256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit inwin(input int idx, input int s, input int c);
        return (idx >= s) && (idx < s + c);
    endfunction

    // Output and link observer, sampled away from the rising edge.
    always @(negedge clk) if (rst_n) begin
        if (rx_out_valid) begin
            got_q.push_back(rx_out_data);
            if (rx_out_src != exp_src || rx_out_type != exp_type) meta_bad++;
        end
        if (rx_frame_done)  done_n++;
        if (rx_frame_error) err_n++;
        if (tx_link_act) begin
            if (tx_hdr_ready) rdy_bad++;
            if (tx_link_vld) begin
                if (lpos == 0) pre_seen = tx_link_data;
                else if (lpos == 1) len_seen = tx_link_data;
                lpos++;
            end
        end else lpos = 0;
    end

    task automatic clear_obs();
        got_q.delete();
        done_n = 0; err_n = 0; meta_bad = 0; rdy_bad = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Send one frame through the loopback and check the result.
    task automatic send_frame(input int len, input logic [2:0] typ, input bit gaps);
        logic [7:0] sent[$];
        logic [7:0] expd[$];
        bit en;
        clear_obs();
        exp_src = tx_port_id; exp_type = typ;
        en = rx_route_en[tx_port_id];
        for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
        tx_hdr_valid = 1'b1; tx_hdr_type = typ; tx_hdr_len = 8'(len);
        @(negedge clk);
        while (!tx_hdr_ready) @(negedge clk);
        step();
        tx_hdr_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin tx_valid = 1'b0; step(); end
            tx_valid = 1'b1; tx_data = pay[i];
            @(negedge clk);
            while (!tx_ready) @(negedge clk);
            step();
        end
        tx_valid = 1'b0;
        repeat (4) step();
        for (int i = 0; i < len; i++) if (inwin(i, tx_win_start, tx_win_cnt)) sent.push_back(pay[i]);
        for (int j = 0; j < sent.size(); j++) if (inwin(j, rx_win_start, rx_win_cnt)) expd.push_back(sent[j]);
        chk(pre_seen == {2'b00, typ, tx_port_id}, "R2 preamble", pre_seen, {2'b00, typ, tx_port_id});
        chk(len_seen == 8'(sent.size()), "R3 length byte", len_seen, sent.size());
        chk(rdy_bad == 0 && tx_hdr_ready, "R9 header ready only when idle", rdy_bad, 0);
        chk(!tx_link_act, "R1 link idle after frame", tx_link_act, 0);
        if (en) begin
            chk(got_q.size() == expd.size(), "R6 forwarded count", got_q.size(), expd.size());
            for (int k = 0; k < expd.size() && k < got_q.size(); k++)
                if (got_q[k] != expd[k]) begin
                    chk(0, "R10 byte-exact delivery", got_q[k], expd[k]);
                    break;
                end
            chk(meta_bad == 0, "R6 source and type", meta_bad, 0);
            chk(done_n == 1 && err_n == 0, "R7 done pulse", done_n, 1);
        end else begin
            if (exp_drop < (1 << DW) - 1) exp_drop++;
            chk(got_q.size() == 0 && done_n == 0, "R4 dropped frame silent", got_q.size(), 0);
        end
        chk(int'(rx_drop_cnt) == exp_drop, "R5 drop count", rx_drop_cnt, exp_drop);
    endtask

    task automatic inj_byte(input bit a, input bit v, input logic [7:0] d);
        inj_act = a; inj_vld = v; inj_data = d; step();
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        exp_src = 3'd0; exp_type = 3'd0; pre_seen = 8'd0; len_seen = 8'd0; lpos = 0;
        clear_obs();
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_out_valid && !rx_frame_done && !rx_frame_error && rx_drop_cnt == 0,
            "R7 reset outputs quiet", rx_drop_cnt, 0);
        chk(tx_hdr_ready && !tx_link_act && !tx_link_vld, "R1 reset link idle", tx_link_act, 0);
        step();

        // Directed: full 255-byte frame, full windows.
        send_frame(255, 3'd2, 1'b0);
        // Zero-length frame.
        send_frame(0, 3'd7, 1'b0);
        // Transmit window starting past the payload end.
        tx_win_start = 8'd20; tx_win_cnt = 8'd5; send_frame(10, 3'd1, 1'b1);
        // Receive window of zero width.
        tx_win_start = 8'd0; tx_win_cnt = 8'd255; rx_win_cnt = 8'd0; send_frame(12, 3'd3, 1'b0);
        // Window whose end passes byte 255.
        rx_win_start = 8'd250; rx_win_cnt = 8'd255; send_frame(255, 3'd4, 1'b0);
        tx_win_start = 8'd240; tx_win_cnt = 8'd200; rx_win_start = 8'd3; rx_win_cnt = 8'd7;
        send_frame(255, 3'd6, 1'b1);

        // Disabled source: drop and saturate the counter.
        tx_win_start = 8'd0; tx_win_cnt = 8'd255; rx_win_start = 8'd0; rx_win_cnt = 8'd255;
        rx_route_en = 8'hFF & ~(8'h1 << tx_port_id);
        for (int n = 0; n < 9; n++) send_frame(3, 3'd0, 1'b0);
        rx_route_en = 8'hFF;
        send_frame(4, 3'd5, 1'b0);

        // Random frames.
        for (int n = 0; n < 40; n++) begin
            tx_port_id   = 3'($urandom);
            rx_route_en  = 8'($urandom) | 8'h0F;
            tx_win_start = ($urandom % 3 == 0) ? 8'($urandom % 40) : 8'd0;
            tx_win_cnt   = 8'($urandom);
            rx_win_start = ($urandom % 3 == 0) ? 8'($urandom % 20) : 8'd0;
            rx_win_cnt   = 8'($urandom);
            send_frame(($urandom % 8 == 0) ? 255 : int'($urandom % 48), 3'($urandom), 1'b1);
        end
        rx_route_en = 8'hFF; rx_win_start = 8'd0; rx_win_cnt = 8'd255;

        // Truncated frame after two payload bytes.
        inj = 1'b1; clear_obs(); exp_src = 3'd2; exp_type = 3'd1;
        inj_byte(1, 1, {2'b00, 3'd1, 3'd2});
        inj_byte(1, 1, 8'd5);
        inj_byte(1, 1, 8'hA5);
        inj_byte(1, 0, 8'h00);
        inj_byte(1, 1, 8'h3C);
        inj_byte(0, 0, 8'h00);
        repeat (3) step();
        chk(err_n == 1 && done_n == 0, "R8 error on early idle", err_n, 1);
        chk(got_q.size() == 2, "R8 bytes before cut forwarded", got_q.size(), 2);
        if (got_q.size() == 2) chk(got_q[0] == 8'hA5 && got_q[1] == 8'h3C, "R6 injected bytes", got_q[1], 8'h3C);

        // Cut right after the preamble.
        clear_obs();
        inj_byte(1, 1, {2'b00, 3'd1, 3'd2});
        inj_byte(0, 0, 8'h00);
        repeat (3) step();
        chk(err_n == 1 && done_n == 0, "R8 error before length byte", err_n, 1);

        // Reserved bits set: dropped, no error on idle.
        clear_obs();
        inj_byte(1, 1, {2'b11, 3'd1, 3'd2});
        inj_byte(1, 1, 8'd1);
        inj_byte(1, 1, 8'h77);
        inj_byte(0, 0, 8'h00);
        repeat (3) step();
        chk(got_q.size() == 0 && done_n == 0 && err_n == 0, "R4 reserved bits dropped",
            got_q.size(), 0);
        chk(int'(rx_drop_cnt) == exp_drop, "R5 drop count held at limit", rx_drop_cnt, exp_drop);
        inj = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule